// File: doc/BRIEF.md
# Dual 40-bit Accumulator ALU

This block is the arithmetic and logic engine for a fixed-point signal processor. It holds two 40-bit accumulators, two 32-bit secondary accumulators and a 16-bit status word. Each clock cycle it either takes one 16-bit write into one register part or runs one operation. An operation uses a destination accumulator select, a 2-bit source select, a 16-bit immediate word and a 40-bit product value that comes from an outside multiplier. Results and flags are registered, so they appear at the outputs one cycle after the operation is presented.

An accumulator has three parts: an 8-bit top byte, a 16-bit middle word and a 16-bit low word. A 16-bit operand is sign-extended and placed at the middle word before an add, subtract or compare, so it lands at bits 31:16. Logic operations and bit tests act on the middle word only. Every result wraps to 40 bits, and bit 39 is the sign.

Top module: `dacc_alu`

## Requirements
- R1: A synchronous active-low reset sets both accumulators, both secondary accumulators and the status word to zero.
- R2: When `wr_en` is 1, `wr_data` goes to the part named by `wr_idx`, and any operation in that cycle is dropped. The part numbers are: 0x10/0x11 top byte of accumulator 0/1 (only data bits 7:0 are used); 0x18/0x19 low word of secondary 0/1; 0x1A/0x1B high word of secondary 0/1; 0x1C/0x1D low word of accumulator 0/1; 0x1E/0x1F middle word of accumulator 0/1. Any other number changes nothing.
- R3: These operations write accumulator D, which is `op_dst`, and set flags. Code 2 writes acc0+acc1. Code 3 writes accD minus the other accumulator. Codes 4 and 5 add or subtract secondary `op_src[0]`, sign-extended from 32 bits. Codes 6 and 7 add or subtract a 16-bit register placed at the middle word: source 0 = secondary 0 low, 1 = secondary 1 low, 2 = secondary 0 high, 3 = secondary 1 high. Code 8 adds the placed immediate. Code 9 adds the placed sign extension of immediate bits 7:0. Code 18 adds `prod_in`.
- R4: Code 13 adds 1, code 14 subtracts 1, code 15 adds 0x10000, code 16 subtracts 0x10000, and code 17 negates accD. All of them set flags.
- R5: The compares set flags from a difference and leave every accumulator unchanged. Code 10 is acc0 − acc1. Code 11 is accD minus the placed high word of secondary `op_src[0]`. Code 12 is accD minus the placed immediate.
- R6: Codes 22/23/24 AND/OR/XOR the middle word of accD with the high word of secondary `op_src[0]`. Codes 25/26/27 do the same with the immediate. The top byte and low word are kept. Zero and sign come from the 16-bit result (sign = bit 15), and carry and overflow are cleared.
- R7: Code 28 sets status bit 6 when (middle word AND immediate) is zero and clears it otherwise. Code 29 sets bit 6 when (middle word AND immediate) equals the immediate and clears it otherwise. Neither changes any other status bit or any accumulator.
- R8: Code 19 copies secondary `op_src[0]` into accD: low to low, high to middle, and the top byte becomes 0xFF when the high word is negative and 0x00 otherwise. Flags come from the result.
- R9: Code 20 shifts accD left by 16 bits. Code 21 shifts accD right by 16 bits arithmetically. Both act on all 40 bits and set flags from the result.
- R10: Code 1 clears accD to zero and sets the flags for a zero result. Code 30 sets the flags from accD and writes nothing.
- R11: Flags are bit 0 carry, bit 1 overflow, bit 2 zero (40-bit result equals 0) and bit 3 sign (bit 39). For an add, carry is the carry out of bit 39. For a subtract, carry is 1 when the minuend, read as an unsigned number, is at least the subtrahend. Overflow is set when the exact signed result falls outside the 40-bit range. Codes 1, 19, 20, 21 and 30 clear carry and overflow.
- R12: Code 0 and code 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 5 | Operation code |
| op_dst | input | 1 | Destination accumulator D |
| op_src | input | 2 | Source select |
| imm_word | input | 16 | Immediate word |
| prod_in | input | 40 | Product value for code 18 |
| wr_en | input | 1 | Register-part write enable |
| wr_idx | input | 5 | Register part number |
| wr_data | input | 16 | Register-part write data |
| acc0_o | output | 40 | Accumulator 0 |
| acc1_o | output | 40 | Accumulator 1 |
| ax0_o | output | 32 | Secondary accumulator 0 |
| ax1_o | output | 32 | Secondary accumulator 1 |
| status_o | output | 16 | Status word |

## Verification
All state sits directly on the outputs, so a wrong operand placement, a wrong carry rule or a write to the wrong part shows up on the cycle right after the operation. A bad flag can stay hidden until the status word is read. For this reason, every operation is checked on all five outputs at once. The sweep covers every code with both destinations and all four sources. It uses zero, all-ones, sign-boundary and random operands, plus immediates drawn from the middle word so that both bit-test outcomes occur.

// File: rtl/dacc_pkg.sv
// Shared widths, register part numbers, status bit positions and operation codes
// for the dual accumulator ALU. The accumulator must be wider than two words.
package dacc_pkg;
    parameter int unsigned ACC_W  = 40;
    parameter int unsigned WORD_W = 16;
    parameter int unsigned SR_W   = 16;
    localparam int unsigned AX_W  = 2 * WORD_W;
    localparam int unsigned HI_W  = ACC_W - AX_W;

    localparam int unsigned FLG_C = 0;
    localparam int unsigned FLG_V = 1;
    localparam int unsigned FLG_Z = 2;
    localparam int unsigned FLG_N = 3;
    localparam int unsigned FLG_T = 6;

    localparam logic [4:0] PART_TOP0 = 5'h10;
    localparam logic [4:0] PART_TOP1 = 5'h11;
    localparam logic [4:0] PART_XL0  = 5'h18;
    localparam logic [4:0] PART_XL1  = 5'h19;
    localparam logic [4:0] PART_XH0  = 5'h1A;
    localparam logic [4:0] PART_XH1  = 5'h1B;
    localparam logic [4:0] PART_LO0  = 5'h1C;
    localparam logic [4:0] PART_LO1  = 5'h1D;
    localparam logic [4:0] PART_MID0 = 5'h1E;
    localparam logic [4:0] PART_MID1 = 5'h1F;

    typedef enum logic [4:0] {
        OP_IDLE  = 5'd0,  OP_CLR   = 5'd1,  OP_ADD   = 5'd2,  OP_SUB   = 5'd3,
        OP_ADDX  = 5'd4,  OP_SUBX  = 5'd5,  OP_ADDW  = 5'd6,  OP_SUBW  = 5'd7,
        OP_ADDI  = 5'd8,  OP_ADDI8 = 5'd9,  OP_CMP   = 5'd10, OP_CMPW  = 5'd11,
        OP_CMPI  = 5'd12, OP_INC   = 5'd13, OP_DEC   = 5'd14, OP_INCM  = 5'd15,
        OP_DECM  = 5'd16, OP_NEG   = 5'd17, OP_ADDP  = 5'd18, OP_MOVX  = 5'd19,
        OP_SHL   = 5'd20, OP_SAR   = 5'd21, OP_ANDX  = 5'd22, OP_ORX   = 5'd23,
        OP_XORX  = 5'd24, OP_ANDI  = 5'd25, OP_ORI   = 5'd26, OP_XORI  = 5'd27,
        OP_TSTZ  = 5'd28, OP_TSTM  = 5'd29, OP_TST   = 5'd30, OP_RSVD  = 5'd31
    } dacc_op_e;

    // Places a signed word at the middle of an accumulator-wide value
    function automatic logic [ACC_W-1:0] place_word(input logic [WORD_W-1:0] w);
        return {{HI_W{w[WORD_W-1]}}, w, {WORD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/dacc_operand_mux.sv
// Builds the adder operands for every add, subtract, compare, step and negate
// operation. A subtract is returned as an inverted B with carry-in set.
// Assumes op is a valid dacc_op_e; other operations give don't-care operands.
module dacc_operand_mux
    import dacc_pkg::*;
#(
    parameter int unsigned AW = ACC_W,
    parameter int unsigned WW = WORD_W
) (
    input  dacc_op_e        op,
    input  logic            dst,
    input  logic [1:0]      src,
    input  logic [AW-1:0]   acc0,
    input  logic [AW-1:0]   acc1,
    input  logic [2*WW-1:0] ax0,
    input  logic [2*WW-1:0] ax1,
    input  logic [WW-1:0]   imm,
    input  logic [AW-1:0]   prod,
    output logic [AW-1:0]   opa,
    output logic [AW-1:0]   opb,
    output logic            cin
);
    localparam int unsigned HW = AW - 2 * WW;

    logic [AW-1:0]   acc_d, acc_o, raw_b, ax_ext;
    logic [2*WW-1:0] ax_s;
    logic [WW-1:0]   reg_w, imm8;
    logic            do_sub;

    // Picks the accumulators, secondary and 16-bit register named by the selects
    always_comb begin
        acc_d  = dst ? acc1 : acc0;
        acc_o  = dst ? acc0 : acc1;
        ax_s   = src[0] ? ax1 : ax0;
        ax_ext = {{HW{ax_s[2*WW-1]}}, ax_s};
        imm8   = {{(WW-8){imm[7]}}, imm[7:0]};
        case (src)
            2'd0:    reg_w = ax0[WW-1:0];
            2'd1:    reg_w = ax1[WW-1:0];
            2'd2:    reg_w = ax0[2*WW-1:WW];
            default: reg_w = ax1[2*WW-1:WW];
        endcase
    end

    // Chooses operand A, the raw operand B and whether B is subtracted
    always_comb begin
        opa    = acc_d;
        raw_b  = '0;
        do_sub = 1'b0;
        case (op)
            OP_ADD:   begin opa = acc0; raw_b = acc1; end
            OP_SUB:   begin raw_b = acc_o; do_sub = 1'b1; end
            OP_ADDX:  raw_b = ax_ext;
            OP_SUBX:  begin raw_b = ax_ext; do_sub = 1'b1; end
            OP_ADDW:  raw_b = place_word(reg_w);
            OP_SUBW:  begin raw_b = place_word(reg_w); do_sub = 1'b1; end
            OP_ADDI:  raw_b = place_word(imm);
            OP_ADDI8: raw_b = place_word(imm8);
            OP_CMP:   begin opa = acc0; raw_b = acc1; do_sub = 1'b1; end
            OP_CMPW:  begin raw_b = place_word(ax_s[2*WW-1:WW]); do_sub = 1'b1; end
            OP_CMPI:  begin raw_b = place_word(imm); do_sub = 1'b1; end
            OP_INC:   raw_b = AW'(1);
            OP_DEC:   begin raw_b = AW'(1); do_sub = 1'b1; end
            OP_INCM:  raw_b = AW'(1) << WW;
            OP_DECM:  begin raw_b = AW'(1) << WW; do_sub = 1'b1; end
            OP_NEG:   begin opa = '0; raw_b = acc_d; do_sub = 1'b1; end
            OP_ADDP:  raw_b = prod;
            default:  ;
        endcase
    end

    // Inverts B and forces carry-in for subtraction
    always_comb begin
        opb = do_sub ? ~raw_b : raw_b;
        cin = do_sub;
    end
endmodule

// File: rtl/dacc_adder.sv
// Accumulator-wide adder with carry-out and signed-overflow detection.
// Assumes that a subtract arrives as an inverted B operand with carry-in 1.
module dacc_adder
    import dacc_pkg::*;
#(
    parameter int unsigned AW = ACC_W
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          cin,
    output logic [AW-1:0] sum,
    output logic          carry,
    output logic          ovf
);
    logic [AW:0] full;

    // Adds with one spare bit to catch the carry out
    always_comb begin
        full  = {1'b0, a} + {1'b0, b} + {{AW{1'b0}}, cin};
        sum   = full[AW-1:0];
        carry = full[AW];
        ovf   = (a[AW-1] == b[AW-1]) && (full[AW-1] != a[AW-1]);
    end
endmodule

// File: rtl/dacc_mid_logic.sv
// Middle-word logic unit: AND/OR/XOR against a secondary high word or the
// immediate, plus the two bit-test outcomes computed against the immediate.
module dacc_mid_logic
    import dacc_pkg::*;
#(
    parameter int unsigned WW = WORD_W
) (
    input  dacc_op_e      op,
    input  logic [WW-1:0] mid,
    input  logic [WW-1:0] axh,
    input  logic [WW-1:0] imm,
    output logic [WW-1:0] res,
    output logic          none_hit,
    output logic          all_hit
);
    logic [WW-1:0] masked;

    // Forms the logic result for the selected operation
    always_comb begin
        case (op)
            OP_ANDX: res = mid & axh;
            OP_ORX:  res = mid | axh;
            OP_XORX: res = mid ^ axh;
            OP_ANDI: res = mid & imm;
            OP_ORI:  res = mid | imm;
            OP_XORI: res = mid ^ imm;
            default: res = mid;
        endcase
    end

    // Evaluates both bit-test conditions
    always_comb begin
        masked   = mid & imm;
        none_hit = (masked == '0);
        all_hit  = (masked == imm);
    end
endmodule

// File: rtl/dacc_alu.sv
// Dual 40-bit accumulator ALU: owns two accumulators, two secondary
// accumulators and the status word. Each cycle it applies either one
// register-part write (which takes priority) or one operation. All state
// is registered and driven straight to the outputs.
module dacc_alu
    import dacc_pkg::*;
#(
    parameter int unsigned AW = ACC_W,
    parameter int unsigned WW = WORD_W,
    parameter int unsigned SW = SR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      op_code,
    input  logic            op_dst,
    input  logic [1:0]      op_src,
    input  logic [WW-1:0]   imm_word,
    input  logic [AW-1:0]   prod_in,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [WW-1:0]   wr_data,
    output logic [AW-1:0]   acc0_o,
    output logic [AW-1:0]   acc1_o,
    output logic [2*WW-1:0] ax0_o,
    output logic [2*WW-1:0] ax1_o,
    output logic [SW-1:0]   status_o
);
    localparam int unsigned XW = 2 * WW;
    localparam int unsigned HW = AW - XW;

    dacc_op_e op;
    logic [1:0][AW-1:0] acc_q, acc_n;
    logic [1:0][XW-1:0] ax_q, ax_n;
    logic [SW-1:0]      sr_q, sr_n;
    logic [AW-1:0]      opa, opb, sum, acc_d, wide_res;
    logic [XW-1:0]      ax_s;
    logic [WW-1:0]      mid_res;
    logic               cin, carry, ovf, none_hit, all_hit;

    assign op = dacc_op_e'(op_code);

    dacc_operand_mux #(.AW(AW), .WW(WW)) u_opmux (
        .op(op), .dst(op_dst), .src(op_src),
        .acc0(acc_q[0]), .acc1(acc_q[1]), .ax0(ax_q[0]), .ax1(ax_q[1]),
        .imm(imm_word), .prod(prod_in),
        .opa(opa), .opb(opb), .cin(cin)
    );

    dacc_adder #(.AW(AW)) u_add (
        .a(opa), .b(opb), .cin(cin), .sum(sum), .carry(carry), .ovf(ovf)
    );

    dacc_mid_logic #(.WW(WW)) u_logic (
        .op(op), .mid(acc_d[XW-1:WW]), .axh(ax_s[XW-1:WW]), .imm(imm_word),
        .res(mid_res), .none_hit(none_hit), .all_hit(all_hit)
    );

    // Computes the full-width move, shift and clear results
    always_comb begin
        acc_d = acc_q[op_dst];
        ax_s  = ax_q[op_src[0]];
        case (op)
            OP_CLR:  wide_res = '0;
            OP_MOVX: wide_res = {{HW{ax_s[XW-1]}}, ax_s};
            OP_SHL:  wide_res = {acc_d[AW-WW-1:0], {WW{1'b0}}};
            OP_SAR:  wide_res = AW'($signed(acc_d) >>> WW);
            default: wide_res = acc_d;
        endcase
    end

    // Selects the next register contents from a write or an operation
    always_comb begin
        acc_n = acc_q;
        ax_n  = ax_q;
        sr_n  = sr_q;
        if (wr_en) begin
            case (wr_idx)
                PART_TOP0: acc_n[0][AW-1:XW]  = wr_data[HW-1:0];
                PART_TOP1: acc_n[1][AW-1:XW]  = wr_data[HW-1:0];
                PART_MID0: acc_n[0][XW-1:WW]  = wr_data;
                PART_MID1: acc_n[1][XW-1:WW]  = wr_data;
                PART_LO0:  acc_n[0][WW-1:0]   = wr_data;
                PART_LO1:  acc_n[1][WW-1:0]   = wr_data;
                PART_XL0:  ax_n[0][WW-1:0]    = wr_data;
                PART_XL1:  ax_n[1][WW-1:0]    = wr_data;
                PART_XH0:  ax_n[0][XW-1:WW]   = wr_data;
                PART_XH1:  ax_n[1][XW-1:WW]   = wr_data;
                default:   ;
            endcase
        end else begin
            case (op)
                OP_ADD, OP_SUB, OP_ADDX, OP_SUBX, OP_ADDW, OP_SUBW, OP_ADDI,
                OP_ADDI8, OP_INC, OP_DEC, OP_INCM, OP_DECM, OP_NEG, OP_ADDP: begin
                    acc_n[op_dst] = sum;
                    sr_n[FLG_N:FLG_C] = {sum[AW-1], sum == '0, ovf, carry};
                end
                OP_CMP, OP_CMPW, OP_CMPI:
                    sr_n[FLG_N:FLG_C] = {sum[AW-1], sum == '0, ovf, carry};
                OP_CLR, OP_MOVX, OP_SHL, OP_SAR: begin
                    acc_n[op_dst] = wide_res;
                    sr_n[FLG_N:FLG_C] = {wide_res[AW-1], wide_res == '0, 2'b00};
                end
                OP_TST:
                    sr_n[FLG_N:FLG_C] = {wide_res[AW-1], wide_res == '0, 2'b00};
                OP_ANDX, OP_ORX, OP_XORX, OP_ANDI, OP_ORI, OP_XORI: begin
                    acc_n[op_dst][XW-1:WW] = mid_res;
                    sr_n[FLG_N:FLG_C] = {mid_res[WW-1], mid_res == '0, 2'b00};
                end
                OP_TSTZ: sr_n[FLG_T] = none_hit;
                OP_TSTM: sr_n[FLG_T] = all_hit;
                default: ;
            endcase
        end
    end

    // Registers all state with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ax_q  <= '0;
            sr_q  <= '0;
        end else begin
            acc_q <= acc_n;
            ax_q  <= ax_n;
            sr_q  <= sr_n;
        end
    end

    assign acc0_o   = acc_q[0];
    assign acc1_o   = acc_q[1];
    assign ax0_o    = ax_q[0];
    assign ax1_o    = ax_q[1];
    assign status_o = sr_q;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (acc0_o == '0 && acc1_o == '0 && ax0_o == '0 && ax1_o == '0 && status_o == '0));

    // R12
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (op_code == 5'd0 || op_code == 5'd31)) |=>
        ($stable(acc0_o) && $stable(acc1_o) && $stable(ax0_o) && $stable(ax1_o) && $stable(status_o)));

    // R5
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (op == OP_CMP || op == OP_CMPW || op == OP_CMPI)) |=>
        ($stable(acc0_o) && $stable(acc1_o)));

    // R6
    logic_mid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !op_dst && (op_code >= 5'd22 && op_code <= 5'd27)) |=>
        (acc0_o[WW-1:0] == $past(acc0_o[WW-1:0]) && acc0_o[AW-1:XW] == $past(acc0_o[AW-1:XW])
         && $stable(acc1_o)));

    // R7
    bittest_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (op == OP_TSTZ || op == OP_TSTM)) |=>
        (status_o[SW-1:FLG_T+1] == $past(status_o[SW-1:FLG_T+1])
         && status_o[FLG_T-1:0] == $past(status_o[FLG_T-1:0])
         && $stable(acc0_o) && $stable(acc1_o)));

    // R4
    inc_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !op_dst && op == OP_INC) |=> (acc0_o == $past(acc0_o) + AW'(1)));

    // R2
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == PART_LO0) |=>
        (acc0_o[WW-1:0] == $past(wr_data) && acc0_o[AW-1:WW] == $past(acc0_o[AW-1:WW])));
endmodule

// File: tb/dacc_alu_tb.sv
module dacc_alu_tb;
    localparam longint unsigned M40 = 64'hFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_code = '0;
    logic        op_dst = 1'b0;
    logic [1:0]  op_src = '0;
    logic [15:0] imm_word = '0;
    logic [39:0] prod_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [39:0] acc0_o, acc1_o;
    logic [31:0] ax0_o, ax1_o;
    logic [15:0] status_o;

    dacc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_dst(op_dst), .op_src(op_src),
        .imm_word(imm_word), .prod_in(prod_in), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .acc0_o(acc0_o), .acc1_o(acc1_o), .ax0_o(ax0_o),
        .ax1_o(ax1_o), .status_o(status_o)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    logic [39:0] m_acc [2];
    logic [31:0] m_ax [2];
    logic [15:0] m_sr;

    function automatic longint s40(input logic [39:0] x);
        return x[39] ? longint'({24'h0, x}) - 64'sh100_0000_0000 : longint'({24'h0, x});
    endfunction

    function automatic logic [39:0] at_mid(input logic [15:0] w);
        longint v = longint'($signed(w)) * 65536;
        return v[39:0];
    endfunction

    task automatic next_rand(output logic [63:0] r);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        r = rng;
    endtask

    task automatic check(input string req);
        vectors++;
        if (acc0_o !== m_acc[0] || acc1_o !== m_acc[1] || ax0_o !== m_ax[0] ||
            ax1_o !== m_ax[1] || status_o !== m_sr) begin
            misses++;
            $display("FAIL %s: got acc0=%h acc1=%h ax0=%h ax1=%h sr=%h exp acc0=%h acc1=%h ax0=%h ax1=%h sr=%h",
                     req, acc0_o, acc1_o, ax0_o, ax1_o, status_o,
                     m_acc[0], m_acc[1], m_ax[0], m_ax[1], m_sr);
        end
    endtask

    task automatic wr(input logic [4:0] idx, input logic [15:0] data);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2: loads every part through the write port
    task automatic load_model(input logic [7:0] junk);
        wr(5'h10, {junk, m_acc[0][39:32]});
        wr(5'h11, {~junk, m_acc[1][39:32]});
        wr(5'h1E, m_acc[0][31:16]);
        wr(5'h1F, m_acc[1][31:16]);
        wr(5'h1C, m_acc[0][15:0]);
        wr(5'h1D, m_acc[1][15:0]);
        wr(5'h18, m_ax[0][15:0]);
        wr(5'h19, m_ax[1][15:0]);
        wr(5'h1A, m_ax[0][31:16]);
        wr(5'h1B, m_ax[1][31:16]);
        wr(5'h05, 16'hDEAD);
    endtask

    task automatic arith(input logic [39:0] a, input logic [39:0] b, input bit sub,
                         output logic [39:0] r);
        longint ua = longint'({24'h0, a});
        longint ub = longint'({24'h0, b});
        longint ex, full;
        logic c, v;
        if (!sub) begin
            full = ua + ub; r = full[39:0]; c = full[40]; ex = s40(a) + s40(b);
        end else begin
            full = ua - ub; r = full[39:0]; c = (ua >= ub); ex = s40(a) - s40(b);
        end
        v = (ex > 64'sd549755813887) || (ex < -64'sd549755813888);
        m_sr[3:0] = {r[39], r == 40'h0, v, c};
    endtask

    task automatic model_op(input int op, input bit d, input logic [1:0] s,
                            input logic [15:0] imm, input logic [39:0] prod);
        logic [39:0] a = m_acc[d];
        logic [39:0] r;
        logic [31:0] x = m_ax[s[0]];
        logic [39:0] xe = {{8{x[31]}}, x};
        logic [15:0] w, mid, lr;
        case (s)
            2'd0: w = m_ax[0][15:0];
            2'd1: w = m_ax[1][15:0];
            2'd2: w = m_ax[0][31:16];
            default: w = m_ax[1][31:16];
        endcase
        mid = a[31:16];
        case (op)
            2:  begin arith(m_acc[0], m_acc[1], 0, r); m_acc[d] = r; end
            3:  begin arith(a, m_acc[!d], 1, r); m_acc[d] = r; end
            4:  begin arith(a, xe, 0, r); m_acc[d] = r; end
            5:  begin arith(a, xe, 1, r); m_acc[d] = r; end
            6:  begin arith(a, at_mid(w), 0, r); m_acc[d] = r; end
            7:  begin arith(a, at_mid(w), 1, r); m_acc[d] = r; end
            8:  begin arith(a, at_mid(imm), 0, r); m_acc[d] = r; end
            9:  begin arith(a, at_mid({{8{imm[7]}}, imm[7:0]}), 0, r); m_acc[d] = r; end
            10: arith(m_acc[0], m_acc[1], 1, r);
            11: arith(a, at_mid(x[31:16]), 1, r);
            12: arith(a, at_mid(imm), 1, r);
            13: begin arith(a, 40'd1, 0, r); m_acc[d] = r; end
            14: begin arith(a, 40'd1, 1, r); m_acc[d] = r; end
            15: begin arith(a, 40'h10000, 0, r); m_acc[d] = r; end
            16: begin arith(a, 40'h10000, 1, r); m_acc[d] = r; end
            17: begin arith(40'd0, a, 1, r); m_acc[d] = r; end
            18: begin arith(a, prod, 0, r); m_acc[d] = r; end
            1, 19, 20, 21, 30: begin
                case (op)
                    1:  r = 40'd0;
                    19: r = {(x[31] ? 8'hFF : 8'h00), x};
                    20: r = 40'((longint'({24'h0, a}) * 65536) & M40);
                    21: r = 40'((s40(a) >>> 16) & M40);
                    default: r = a;
                endcase
                if (op != 30) m_acc[d] = r;
                m_sr[3:0] = {r[39], r == 40'h0, 2'b00};
            end
            22, 23, 24, 25, 26, 27: begin
                case (op)
                    22: lr = mid & x[31:16];
                    23: lr = mid | x[31:16];
                    24: lr = mid ^ x[31:16];
                    25: lr = mid & imm;
                    26: lr = mid | imm;
                    default: lr = mid ^ imm;
                endcase
                m_acc[d][31:16] = lr;
                m_sr[3:0] = {lr[15], lr == 16'h0, 2'b00};
            end
            28: m_sr[6] = ((mid & imm) == 16'h0);
            29: m_sr[6] = ((mid & imm) == imm);
            default: ;
        endcase
    endtask

    function automatic string req_of(input int op);
        case (op)
            0, 31: return "R12";
            1, 30: return "R10";
            10, 11, 12: return "R5";
            13, 14, 15, 16, 17: return "R4";
            19: return "R8";
            20, 21: return "R9";
            22, 23, 24, 25, 26, 27: return "R6";
            28, 29: return "R7";
            default: return "R3/R11";
        endcase
    endfunction

    task automatic fill_pattern(input int p);
        logic [63:0] r0, r1, r2;
        case (p)
            0: begin m_acc[0] = '0; m_acc[1] = '0; m_ax[0] = '0; m_ax[1] = '0; end
            1: begin m_acc[0] = '1; m_acc[1] = '1; m_ax[0] = '1; m_ax[1] = '1; end
            2: begin m_acc[0] = 40'h7F_FFFF_FFFF; m_acc[1] = 40'h80_0000_0000;
                     m_ax[0] = 32'h7FFF_8000; m_ax[1] = 32'h8000_7FFF; end
            3: begin m_acc[0] = 40'h00_FFFF_0000; m_acc[1] = 40'hFF_0001_0000;
                     m_ax[0] = 32'h8000_0001; m_ax[1] = 32'h0001_FFFF; end
            default: begin
                next_rand(r0); next_rand(r1); next_rand(r2);
                m_acc[0] = r0[39:0]; m_acc[1] = r1[39:0];
                m_ax[0] = r2[31:0]; m_ax[1] = r2[63:32];
            end
        endcase
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [63:0] rv;
        logic [15:0] imm;
        logic [39:0] prod;
        m_acc[0] = '0; m_acc[1] = '0; m_ax[0] = '0; m_ax[1] = '0; m_sr = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset");
        for (int p = 0; p < 10; p++) begin
            for (int op = 0; op < 32; op++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int s = 0; s < 4; s++) begin
                        fill_pattern(p);
                        load_model(8'hA5);
                        check("R2 load");
                        next_rand(rv);
                        case (p)
                            0: imm = 16'h0000;
                            1: imm = 16'hFFFF;
                            2: imm = (s[0]) ? 16'h8000 : 16'h007F;
                            default: imm = (s >= 2) ? (m_acc[d][31:16] & rv[15:0]) : rv[15:0];
                        endcase
                        prod = (p == 2) ? 40'h00_0000_0001 : rv[55:16];
                        op_code = 5'(op); op_dst = d[0]; op_src = 2'(s); imm_word = imm; prod_in = prod;
                        model_op(op, d[0], 2'(s), imm, prod);
                        @(negedge clk);
                        op_code = 5'd0;
                        check(req_of(op));
                    end
                end
            end
        end
        // R2: a write in the same cycle as an increment wins and the increment is dropped
        op_code = 5'd13; op_dst = 1'b0;
        wr(5'h1C, 16'h1234);
        op_code = 5'd0;
        m_acc[0][15:0] = 16'h1234;
        check("R2 write priority");
        // R1: reset again from a loaded state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_acc[0] = '0; m_acc[1] = '0; m_ax[0] = '0; m_ax[1] = '0; m_sr = '0;
        check("R1 reset reapply");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule